// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block turns the system clock into the timing base for an I2C master's serial clock. Software programs one byte-wide period register. The top bit of each write chooses one of two stored timer values: the one used for high-speed transfers, or the one shared by standard, fast and fast-plus transfers. The chosen 7-bit value `t` sets an SCL half period of `10*(1+t)` system clocks. The resulting SCL rate is therefore `FCLK_HZ / (20*(1+t))`.

The block produces three outputs. The first is a one-cycle strobe at every SCL edge. The second is a free-running SCL reference level that flips on each strobe. The third is a two-bit speed-mode code, classified from the rate actually in force. Settings that would run faster than 3.4 MHz, or faster than one tenth of the system clock, are raised to the slowest divider that respects both limits.

A new setting never cuts a half period short. It is picked up only at the next SCL edge. A synchronous soft-reset input, driven from a control-register bit, returns the divider and both stored timers to their reset state. The block does not track changes of the system clock. After a clock change, software must program a new value. Byte sequencing, SDA, stretching and arbitration belong to the consumer of the strobe.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: During and right after reset, `rd_data` reads 0x01, `scl_ref` is 1, `scl_toggle` is 0, and `speed_mode` is the code of the clamped reset setting. With the default 200 MHz clock this code is 2.
- R2: A write with `wr_data[7]`=1 stores `wr_data[6:0]` as the high-speed timer. A write with `wr_data[7]`=0 stores it as the standard/fast/fast-plus timer. Either write leaves the other timer unchanged. From the next cycle, `rd_data` returns the last written bit 7 together with the timer that bit selects.
- R3: Consecutive SCL edges are exactly `10*S` clocks apart, where S is the effective step count latched at the previous edge. `scl_toggle` is high for one cycle at each edge. `scl_ref` inverts in that same cycle and holds at all other times.
- R4: The effective step count is S = max(1+t, Smin). Smin is the smallest step count for which `FCLK_HZ/(20*S)` is at most both 3.4 MHz and `FCLK_HZ/10`. At 200 MHz, Smin = 3, so the shortest half period is 30 clocks.
- R5: While `hs_enable` is 1, the high-speed timer drives the divider. While it is 0, the standard/fast/fast-plus timer drives it.
- R6: The timer value and `hs_enable` are sampled only at an SCL edge. This includes the reset-to-first-edge interval. A write in any other cycle does not change the half period that is already running. A write in the edge cycle itself takes effect one edge later.
- R7: `speed_mode` is computed from the rate r of the latched setting. It is 3 (high-speed) when the high-speed timer is in use and r > 1 MHz. Otherwise it is 2 (fast-plus) when r > 400 kHz, 1 (fast) when r > 100 kHz, and 0 (standard) otherwise. It changes only in an edge cycle or right after a soft reset.
- R8: `soft_rst`=1 at a clock edge restores the state of R1 and takes priority over a write in the same cycle. The next half period is counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset from the control register |
| hs_enable | input | 1 | Use the high-speed timer for the divider |
| wr_en | input | 1 | Period register write strobe |
| wr_data | input | 8 | Bit 7 selects the timer; bits 6..0 are the timer value |
| rd_data | output | 8 | Select flag and the currently selected timer |
| scl_toggle | output | 1 | One-cycle strobe at each SCL edge |
| scl_ref | output | 1 | Free-running SCL reference level |
| speed_mode | output | 2 | 0 standard, 1 fast, 2 fast-plus, 3 high-speed |

## Verification
A wrong divider count or a bad latched step value shows up within one half period, at most 1280 clocks. It appears as a strobe arriving early or late, and `scl_ref` then stays out of phase for the rest of the run. A timer written into the wrong slot appears on `rd_data` in the cycle after the write. If that slot is the active one, the next half period also has the wrong length. A mode classification fault is visible on `speed_mode` from the first edge after the setting changes. The reference model steps through the same edges on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_FPLUS = 2'd2,
    SPD_HS    = 2'd3
  } spd_mode_e;

  function automatic longint ceil_div(input longint num, input longint den);
    return (num + den - 1) / den;
  endfunction

  // Classify a step count: a smaller step count means a faster rate.
  // gt_* is the largest step count whose rate lies strictly above that band limit.
  function automatic spd_mode_e classify(input int steps, input logic hs_used,
                                         input int gt_fplus, input int gt_fast,
                                         input int gt_std);
    if (hs_used && steps <= gt_fplus) return SPD_HS;
    if (steps <= gt_fast)             return SPD_FPLUS;
    if (steps <= gt_std)              return SPD_FAST;
    return SPD_STD;
  endfunction

endpackage

// File: rtl/scl_period_regs.sv
module scl_period_regs #(
  parameter int TIMER_W   = 7,
  parameter int RST_TIMER = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               wr_en,
  input  logic [TIMER_W:0]   wr_data,
  output logic [TIMER_W-1:0] hs_timer,
  output logic [TIMER_W-1:0] sf_timer,
  output logic [TIMER_W:0]   rd_data
);

  localparam logic [TIMER_W-1:0] RST_VAL = TIMER_W'(RST_TIMER);

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 1'b0;
    else if (soft_rst) sel_q <= 1'b0;
    else if (wr_en)    sel_q <= wr_data[TIMER_W];
  end

  // Bank 0 holds the standard/fast/fast-plus timer, bank 1 the high-speed one.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BANK_ID = (b == 1);
    logic [TIMER_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= RST_VAL;
      else if (soft_rst)
        q <= RST_VAL;
      else if (wr_en && (wr_data[TIMER_W] == BANK_ID))
        q <= wr_data[TIMER_W-1:0];
    end
  end

  assign sf_timer = g_bank[0].q;
  assign hs_timer = g_bank[1].q;
  assign rd_data  = {sel_q, (sel_q ? hs_timer : sf_timer)};

endmodule

// File: rtl/scl_step_select.sv
module scl_step_select
  import scl_rate_pkg::*;
#(
  parameter int TIMER_W  = 7,
  parameter int MIN_STEP = 3,
  parameter int GT_FPLUS = 9,
  parameter int GT_FAST  = 24,
  parameter int GT_STD   = 99
) (
  input  logic               hs_enable,
  input  logic [TIMER_W-1:0] hs_timer,
  input  logic [TIMER_W-1:0] sf_timer,
  output logic [TIMER_W:0]   next_steps,
  output spd_mode_e          next_mode
);

  localparam int STEP_W = TIMER_W + 1;

  logic [TIMER_W-1:0] tsel;
  logic [STEP_W-1:0]  raw_steps;

  assign tsel      = hs_enable ? hs_timer : sf_timer;
  assign raw_steps = {1'b0, tsel} + STEP_W'(1);

  if (MIN_STEP > 1) begin : g_clamp
    localparam logic [STEP_W-1:0] FLOOR = STEP_W'(MIN_STEP);
    assign next_steps = (raw_steps < FLOOR) ? FLOOR : raw_steps;
  end else begin : g_noclamp
    assign next_steps = raw_steps;
  end

  always_comb begin
    next_mode = classify(int'(next_steps), hs_enable, GT_FPLUS, GT_FAST, GT_STD);
  end

endmodule

// File: rtl/scl_half_divider.sv
module scl_half_divider
  import scl_rate_pkg::*;
#(
  parameter int        STEP_W    = 8,
  parameter int        CNT_W     = 11,
  parameter int        PHASE_MUL = 10,
  parameter int        RST_STEPS = 3,
  parameter spd_mode_e RST_MODE  = SPD_FPLUS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [STEP_W-1:0] next_steps,
  input  spd_mode_e         next_mode,
  output logic              scl_toggle,
  output logic              scl_ref,
  output spd_mode_e         speed_mode
);

  localparam logic [CNT_W-1:0] RST_HALF = CNT_W'(PHASE_MUL * RST_STEPS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] half_load;
  logic             edge_now;

  assign half_load = CNT_W'(PHASE_MUL * int'(next_steps));
  assign edge_now  = (cnt_q == half_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      half_q     <= RST_HALF;
      scl_ref    <= 1'b1;
      scl_toggle <= 1'b0;
      speed_mode <= RST_MODE;
    end else if (soft_rst) begin
      cnt_q      <= '0;
      half_q     <= RST_HALF;
      scl_ref    <= 1'b1;
      scl_toggle <= 1'b0;
      speed_mode <= RST_MODE;
    end else if (edge_now) begin
      cnt_q      <= '0;
      half_q     <= half_load;
      scl_ref    <= ~scl_ref;
      scl_toggle <= 1'b1;
      speed_mode <= next_mode;
    end else begin
      cnt_q      <= cnt_q + CNT_W'(1);
      scl_toggle <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int FCLK_HZ      = 200_000_000,
  parameter int TIMER_W      = 7,
  parameter int PHASE_MUL    = 10,
  parameter int HS_MAX_HZ    = 3_400_000,
  parameter int FPLUS_MAX_HZ = 1_000_000,
  parameter int FAST_MAX_HZ  = 400_000,
  parameter int STD_MAX_HZ   = 100_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             hs_enable,
  input  logic             wr_en,
  input  logic [TIMER_W:0] wr_data,
  output logic [TIMER_W:0] rd_data,
  output logic             scl_toggle,
  output logic             scl_ref,
  output logic [1:0]       speed_mode
);

  localparam int     STEP_W    = TIMER_W + 1;
  localparam int     STEP_MAX  = 1 << TIMER_W;
  localparam longint PHASE_DIV = 2 * PHASE_MUL;
  localparam int     RST_TIMER = 1;

  // Slowest-divider clamp: both the absolute cap and the Fclk/10 cap.
  localparam int RATE_STEP = int'(ceil_div(longint'(FCLK_HZ), PHASE_DIV * HS_MAX_HZ));
  localparam int SYS_STEP  = int'(ceil_div(10, PHASE_DIV));
  localparam int MIN_RAW   = (RATE_STEP > SYS_STEP) ? RATE_STEP : SYS_STEP;
  localparam int MIN_STEP  = (MIN_RAW < 1) ? 1 : ((MIN_RAW > STEP_MAX) ? STEP_MAX : MIN_RAW);

  localparam int GT_FPLUS = int'(ceil_div(longint'(FCLK_HZ), PHASE_DIV * FPLUS_MAX_HZ)) - 1;
  localparam int GT_FAST  = int'(ceil_div(longint'(FCLK_HZ), PHASE_DIV * FAST_MAX_HZ)) - 1;
  localparam int GT_STD   = int'(ceil_div(longint'(FCLK_HZ), PHASE_DIV * STD_MAX_HZ)) - 1;

  localparam int        RST_STEPS = ((RST_TIMER + 1) < MIN_STEP) ? MIN_STEP : (RST_TIMER + 1);
  localparam spd_mode_e RST_MODE  = classify(RST_STEPS, 1'b0, GT_FPLUS, GT_FAST, GT_STD);
  localparam int        HALF_MAX  = PHASE_MUL * STEP_MAX;
  localparam int        CNT_W     = $clog2(HALF_MAX + 1);
  localparam int        MIN_HALF  = PHASE_MUL * MIN_STEP;

  logic [TIMER_W-1:0] hs_timer;
  logic [TIMER_W-1:0] sf_timer;
  logic [STEP_W-1:0]  next_steps;
  spd_mode_e          next_mode;
  spd_mode_e          mode_q;

  scl_period_regs #(
    .TIMER_W  (TIMER_W),
    .RST_TIMER(RST_TIMER)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .hs_timer(hs_timer),
    .sf_timer(sf_timer),
    .rd_data (rd_data)
  );

  scl_step_select #(
    .TIMER_W (TIMER_W),
    .MIN_STEP(MIN_STEP),
    .GT_FPLUS(GT_FPLUS),
    .GT_FAST (GT_FAST),
    .GT_STD  (GT_STD)
  ) u_sel (
    .hs_enable (hs_enable),
    .hs_timer  (hs_timer),
    .sf_timer  (sf_timer),
    .next_steps(next_steps),
    .next_mode (next_mode)
  );

  scl_half_divider #(
    .STEP_W   (STEP_W),
    .CNT_W    (CNT_W),
    .PHASE_MUL(PHASE_MUL),
    .RST_STEPS(RST_STEPS),
    .RST_MODE (RST_MODE)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .next_steps(next_steps),
    .next_mode (next_mode),
    .scl_toggle(scl_toggle),
    .scl_ref   (scl_ref),
    .speed_mode(mode_q)
  );

  assign speed_mode = mode_q;

endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int TIMER_W  = 7,
  parameter int MIN_HALF = 30,
  parameter int CNT_W    = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             wr_en,
  input logic [TIMER_W:0] wr_data,
  input logic [TIMER_W:0] rd_data,
  input logic             scl_toggle,
  input logic             scl_ref,
  input logic [1:0]       speed_mode
);

  localparam int GAP_W = CNT_W + 1;
  localparam logic [GAP_W-1:0] GAP_SAT = '1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (soft_rst || scl_toggle) gap_q <= '0;
    else if (gap_q != GAP_SAT)       gap_q <= gap_q + GAP_W'(1);
  end

  // R3
  toggle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_toggle |=> !scl_toggle);

  // R3
  ref_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_toggle |-> (scl_ref != $past(scl_ref)));

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_toggle && !$past(soft_rst)) |-> $stable(scl_ref));

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> (rd_data == $past(wr_data)));

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data == (TIMER_W+1)'(1) && scl_ref && !scl_toggle));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_mode != $past(speed_mode)) |-> (scl_toggle || $past(soft_rst)));

  // R4
  min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_toggle |-> (gap_q >= GAP_W'(MIN_HALF - 1)));

endmodule

bind i2c_scl_rate_gen scl_rate_chk #(
  .TIMER_W (TIMER_W),
  .MIN_HALF(MIN_HALF),
  .CNT_W   (CNT_W)
) u_scl_rate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .scl_toggle(scl_toggle),
  .scl_ref   (scl_ref),
  .speed_mode(speed_mode)
);

// File: tb/tb_i2c_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       hs_enable = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       scl_toggle;
  logic       scl_ref;
  logic [1:0] speed_mode;

  always #2.5 clk = ~clk;  // 200 MHz

  i2c_scl_rate_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .hs_enable (hs_enable),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .scl_toggle(scl_toggle),
    .scl_ref   (scl_ref),
    .speed_mode(speed_mode)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  bit    done    = 0;
  string phase   = "R1 reset";

  // Behavioural reference (R4: smallest step count meeting both rate caps).
  function automatic int eff_steps(input int t);
    int smin = 1;
    while ((200.0e6 / (20.0 * smin) > 3.4e6) || (200.0e6 / (20.0 * smin) > 200.0e6 / 10.0))
      smin++;
    return ((t + 1) < smin) ? smin : (t + 1);
  endfunction

  // R7: classification from the real-valued rate.
  function automatic int mode_of(input int s, input bit hs);
    real r = 200.0e6 / (20.0 * s);
    if (hs && r > 1.0e6) return 3;
    if (r > 400.0e3)     return 2;
    if (r > 100.0e3)     return 1;
    return 0;
  endfunction

  bit m_sel;
  int m_hs, m_sf, m_cnt, m_half, m_mode;
  bit m_ref, m_tick;

  task automatic model_reset();
    m_sel = 0; m_hs = 1; m_sf = 1; m_cnt = 0;
    m_half = 10 * eff_steps(1);
    m_mode = mode_of(eff_steps(1), 1'b0);
    m_ref = 1; m_tick = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else if (soft_rst) model_reset();  // R8
    else begin
      if (m_cnt == m_half - 1) begin  // R6: sample settings at the edge only
        int s;
        s = eff_steps(hs_enable ? m_hs : m_sf);  // R5
        m_cnt = 0; m_ref = !m_ref; m_tick = 1;
        m_half = 10 * s;
        m_mode = mode_of(s, hs_enable);
      end else begin
        m_cnt++; m_tick = 0;
      end
      if (wr_en) begin  // R2
        m_sel = wr_data[7];
        if (wr_data[7]) m_hs = int'(wr_data[6:0]);
        else            m_sf = int'(wr_data[6:0]);
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    if (!done) begin
      exp_rd = {m_sel, (m_sel ? 7'(m_hs) : 7'(m_sf))};
      vectors++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL R2 [%s] rd_data act=%h exp=%h", phase, rd_data, exp_rd);
      end
      if (scl_toggle !== m_tick) begin
        errors++;
        $display("FAIL R3 [%s] scl_toggle act=%b exp=%b", phase, scl_toggle, m_tick);
      end
      if (scl_ref !== m_ref) begin
        errors++;
        $display("FAIL R3 [%s] scl_ref act=%b exp=%b", phase, scl_ref, m_ref);
      end
      if (speed_mode !== 2'(m_mode)) begin
        errors++;
        $display("FAIL R7 [%s] speed_mode act=%0d exp=%0d", phase, speed_mode, m_mode);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog [%s] act=%0d cycles exp=<150000", phase, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    phase = "R1 reset";
    idle(5);
    rst_n = 1;
    idle(40);

    phase = "R4 clamp of reset value";
    idle(100);

    phase = "R2 R5 standard bank write";
    wr(8'h05);
    wr(8'hB3);  // high-speed bank, divider untouched while hs_enable=0
    idle(200);

    phase = "R7 standard band";
    wr(8'h63);
    idle(2200);

    phase = "R7 fast band limit";
    wr(8'h18);
    idle(700);

    phase = "R5 R4 high-speed clamp";
    wr(8'h80);
    hs_enable = 1;
    idle(300);

    phase = "R7 high-speed timer below 1 MHz";
    wr(8'h8A);
    idle(400);

    phase = "R6 mid-period rewrite";
    wr(8'h8C);
    idle(7);
    wr(8'h81);
    idle(300);
    hs_enable = 0;
    idle(300);

    phase = "R8 soft reset with write";
    idle(13);
    @(negedge clk); soft_rst = 1; wr_en = 1; wr_data = 8'h9F;
    @(negedge clk); soft_rst = 0; wr_en = 0;
    idle(100);

    phase = "R6 R5 random writes";
    for (int i = 0; i < 60; i++) begin
      idle(int'($urandom_range(1, 300)));
      @(negedge clk);
      wr_en = 1;
      wr_data = 8'($urandom_range(0, 255));
      hs_enable = 1'($urandom_range(0, 1));
      soft_rst = ($urandom_range(0, 15) == 0);
      @(negedge clk);
      wr_en = 0; soft_rst = 0;
    end
    idle(2000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule